// File: doc/BRIEF.md
# Logic Array Power-Down Controller

This block sits between a bus-attached processor and a small programmable logic array and decides when the array may sleep. Software controls it through two mode registers in an internal register window. One register holds a turbo bit. The other holds one blocking bit per array input. The array itself is represented by a fixed combinational function: output bit j is the XOR of gated inputs 2j and 2j+1.

With turbo set, the array output follows its inputs in the same cycle. With turbo clear, the output is frozen in a holding register. It is refreshed only when a gated input differs from its value at the previous clock. The refresh appears one clock after the change, which is the wake penalty. A blocked input presents the array with the value it had when blocking began, so blocking never creates an edge of its own.

An inactivity monitor counts clocks in which the address-latch strobe is absent. Once the count reaches a programmable limit, the monitor raises a power-down indication, and the array is put to sleep as if turbo were clear. Any strobe drops the indication in that same cycle and restarts the count.

Top module: `pld_power_ctl`

## Requirements
- R1: After reset, the turbo bit is 1, every blocking bit is 0 and the inactivity count is 0. Reading offset 0 returns 0x01 and offset 2 returns 0x00.
- R2: Offset 0 holds turbo in bit 0, and its other bits read 0. Offset 2 holds the blocking bits, where bit i blocks input i. Both are written on a clock edge with reg_wr high and read combinationally. Any other offset reads 0 and ignores writes.
- R3: When awake (turbo 1 and pwr_down 0), pld_out[j] equals gated[2j] XOR gated[2j+1] in the same cycle, and asleep is 0.
- R4: When in sleep (turbo 0 or pwr_down 1), pld_out keeps its value while the gated inputs equal their values at the previous clock, and asleep is 1.
- R5: In sleep, a cycle in which a gated input differs from the previous clock shows asleep 0 and the old pld_out. From the next clock, pld_out shows the function of the new inputs.
- R6: A blocked input is seen by the array at the raw value it had on the clock edge that set its blocking bit. Changes on that pin then neither change pld_out nor wake the array.
- R7: pwr_down is 1 in a cycle with ale low once at least idle_limit clock edges have passed without ale since the last edge with ale high (or since reset). The count saturates at the limit.
- R8: ale high forces pwr_down to 0 in the same cycle and restarts the inactivity count from 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pld_in | input | 8 | Raw array inputs |
| ale | input | 1 | Address-latch strobe from the bus |
| idle_limit | input | 8 | Idle clocks before power-down |
| pld_out | output | 4 | Array outputs |
| asleep | output | 1 | Array is idle this cycle |
| pwr_down | output | 1 | Inactivity power-down indication |

## Verification
The bench checks the cycle in which an input changes during sleep. A design that refreshes at once or never would show the new output a cycle early or stay stale. Blocking is checked with a pin that toggles after its bit is set. A design that forced blocked inputs to 0 would flip the output bit, and one that did not block would track the pin. The inactivity limit is checked exactly: a counter that is off by one raises power-down one cycle early or late. The bench also drives ale while power-down is active, so a registered clear would lag by a cycle.

// File: rtl/pld_power_ctl.sv
module pld_power_ctl #(
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [2*N_OUT-1:0]    reg_wdata,
  output logic [2*N_OUT-1:0]    reg_rdata,
  input  logic [2*N_OUT-1:0]    pld_in,
  input  logic                  ale,
  input  logic [CNT_W-1:0]      idle_limit,
  output logic [N_OUT-1:0]      pld_out,
  output logic                  asleep,
  output logic                  pwr_down
);
  localparam int N_IN = 2 * N_OUT;
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_GATE = ADDR_W'(2);

  logic              turbo_q;
  logic [N_IN-1:0]   gate_q, hold_q, prev_q, gated;
  logic [N_OUT-1:0]  fx, lat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sleep, chg;

  assign gated = (gate_q & hold_q) | (~gate_q & pld_in);

  for (genvar j = 0; j < N_OUT; j++) begin : g_fn
    assign fx[j] = gated[2*j] ^ gated[2*j+1];
  end

  assign pwr_down = ~ale & (cnt_q >= idle_limit);
  assign sleep    = ~turbo_q | pwr_down;
  assign chg      = gated != prev_q;
  assign asleep   = sleep & ~chg;
  assign pld_out  = sleep ? lat_q : fx;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_MODE) reg_rdata[0] = turbo_q;
    else if (reg_addr == OFS_GATE) reg_rdata = gate_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turbo_q <= 1'b1;
      gate_q  <= '0;
      hold_q  <= '0;
      prev_q  <= '0;
      lat_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_MODE) turbo_q <= reg_wdata[0];
      if (reg_wr && reg_addr == OFS_GATE) gate_q  <= reg_wdata;
      hold_q <= gated;
      prev_q <= gated;
      if (!sleep || chg) lat_q <= fx;
      if (ale) cnt_q <= '0;
      else if (cnt_q < idle_limit) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

module pld_power_ctl_chk #(
  parameter int N_OUT = 4,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ale,
  input logic [CNT_W-1:0]     idle_limit,
  input logic [N_OUT-1:0]     pld_out,
  input logic                 asleep,
  input logic                 pwr_down,
  input logic                 turbo_q,
  input logic [2*N_OUT-1:0]   gate_q,
  input logic [2*N_OUT-1:0]   gated,
  input logic [N_OUT-1:0]     fx,
  input logic                 sleep,
  input logic                 chg
);
  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  p_strobe_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !pwr_down);

  p_awake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_q && !pwr_down) |-> !asleep);

  p_pd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !ale && $past(pwr_down) && $stable(idle_limit)) |-> pwr_down);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && sleep && $past(sleep) && !chg && !$past(chg)) |-> $stable(pld_out));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && chg) |=> (!sleep || pld_out == $past(fx)));

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((gate_q & $past(gate_q) & (gated ^ $past(gated))) == '0));
endmodule

bind pld_power_ctl pld_power_ctl_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_pld_power_ctl.sv
module test_pld_power_ctl;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0, reg_wr = 0, ale = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, pld_in = 0, idle_limit = 8'd5;
  logic [3:0] pld_out;
  logic       asleep, pwr_down;
  int total = 0, bad = 0;

  logic       m_turbo;
  logic [7:0] m_gate, m_hold, m_prev, m_cnt;
  logic [3:0] m_lat;

  always #(CLK_P/2) clk = ~clk;

  pld_power_ctl i_pld_power_ctl (.*);

  function automatic logic [3:0] f(input logic [7:0] g);
    for (int j = 0; j < 4; j++) f[j] = g[2*j] ^ g[2*j+1];
  endfunction

  function automatic logic [7:0] m_gated();
    return (m_gate & m_hold) | (~m_gate & pld_in);
  endfunction

  function automatic logic m_pd();
    return !ale && (m_cnt >= idle_limit);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_turbo = 1; m_gate = 0; m_hold = 0; m_prev = 0; m_lat = 0; m_cnt = 0;
  endtask

  task automatic cycle();
    logic [7:0] g;
    logic sl, ch;
    logic [7:0] rd;
    #(CLK_P/4);
    g  = m_gated();
    sl = !m_turbo || m_pd();
    ch = g != m_prev;
    rd = (reg_addr == 0) ? {7'd0, m_turbo} : (reg_addr == 2) ? m_gate : 8'd0;
    if (rst_n) begin
      chk(sl ? "R4" : "R3", pld_out, sl ? m_lat : f(g));
      chk("R5", asleep, sl && !ch);
      chk("R7", pwr_down, m_pd());
      chk("R2", reg_rdata, rd);
    end
    @(posedge clk);
    if (!rst_n) m_reset();
    else begin
      if (reg_wr && reg_addr == 0) m_turbo = reg_wdata[0];
      if (reg_wr && reg_addr == 2) m_gate = reg_wdata;
      if (!sl || ch) m_lat = f(g);
      m_hold = g; m_prev = g;
      if (ale) m_cnt = 0; else if (m_cnt < idle_limit) m_cnt = m_cnt + 1;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 0; reg_addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1", reg_rdata, 8'h01);
    reg_addr = 2; #1;
    chk("R1", reg_rdata, 8'h00);
    reg_addr = 0;
    @(negedge clk);
    rst_n = 1;
    ale = 1; cycle(); ale = 0;
    chk("R1", pwr_down, 0);

    // R2: write, read back, stray offset
    wr(4'd0, 8'hFE);
    #1 chk("R2", reg_rdata, 8'h00);
    wr(4'd5, 8'hFF);
    reg_addr = 5; #1 chk("R2", reg_rdata, 8'h00);
    reg_addr = 0; #1 chk("R2", reg_rdata, 8'h00);

    // R5: wake penalty with turbo off
    ale = 1;
    pld_in = 8'h00; cycle(); cycle();
    pld_in = 8'h01; #1;
    chk("R5", pld_out, 4'h0);
    cycle();
    #1 chk("R5", pld_out, 4'h1);
    cycle();

    // R6: block input 0 while it is 1, then toggle it
    wr(4'd2, 8'h01);
    wr(4'd0, 8'h01);
    pld_in = 8'h00; #1;
    chk("R6", pld_out, 4'h1);
    cycle();
    #1 chk("R6", pld_out, 4'h1);
    wr(4'd2, 8'h00);
    cycle();

    // R7 and R8: exact idle limit, then strobe clears in the same cycle
    idle_limit = 8'd4;
    cycle(); ale = 0;
    for (int k = 0; k < 4; k++) begin
      #1 chk("R7", pwr_down, 0);
      cycle();
    end
    #1 chk("R7", pwr_down, 1);
    cycle();
    ale = 1; #1 chk("R8", pwr_down, 0);
    cycle(); ale = 0;
    #1 chk("R8", pwr_down, 0);
    idle_limit = 8'd0; #1 chk("R7", pwr_down, 1);
    cycle();

    // mixed random phase
    for (int n = 0; n < 6000; n++) begin
      if (n % 500 == 0) idle_limit = 8'($urandom_range(0, 12));
      ale = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 3) == 0) pld_in = 8'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        reg_wr = 1;
        reg_addr = ($urandom_range(0, 3) == 0) ? 4'($urandom) : (($urandom_range(0, 1) != 0) ? 4'd0 : 4'd2);
        reg_wdata = 8'($urandom);
      end else begin
        reg_wr = 0;
        reg_addr = ($urandom_range(0, 1) != 0) ? 4'd0 : 4'd2;
      end
      cycle();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule